// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block keeps the interrupt bookkeeping of a serial port: an eleven-bit raw status word, an eleven-bit enable mask, and the six interrupt lines that follow from them. The receive, transmit, timeout and error logic around it reports events as one-cycle set strobes. The four modem-status sources arrive as levels, and any change of a level is recorded as an event. Software reaches the block through a small register port with a two-bit address and separate read and write strobes.

Status bits stay set until software clears them. It does so by writing ones to the clear address. One combined line and five grouped lines are driven from the masked status, which is the raw status ANDed with the mask. Every output is registered. The block holds no state machine: its behaviour is a set/clear register, a mask register, a registered OR tree and a registered read multiplexer.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Bit k of `ev_set_i` (k = 0..6) sets raw status bit k+4. The raw positions are: receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10.
- R2: A change in either direction of `ms_lvl_i` bit m (m = 0..3) sets raw bit m. Bit 0 is RI, bit 1 is CTS, bit 2 is DCD and bit 3 is DSR. A level that holds steady sets nothing. The sampled levels are zero after reset.
- R3: A raw status bit that has been set stays set, however many cycles pass, until it is cleared.
- R4: A write to address 3 clears each raw bit that is 1 in `reg_wdata_i` and leaves the other bits unchanged. Writing zero has no effect.
- R5: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Address 0 is the mask, which can be read and written. A read of address 1 returns the raw status, and a read of address 2 returns raw AND mask. A raw bit whose mask bit is 0 drives no line.
- R7: `irq_o` is high when any bit of raw AND mask is set.
- R8: Each grouped line follows only its own bits of raw AND mask. `irq_err_o` covers bits 10..7, `irq_ms_o` covers bits 3..0, `irq_rt_o` covers bit 6, `irq_tx_o` covers bit 5 and `irq_rx_o` covers bit 4.
- R9: All interrupt lines are registered. They change one clock after the edge that updates the raw status or the mask, and a mask write alone is enough to change them.
- R10: Reset clears the raw status, the mask, every interrupt line and `reg_rdata_o`.
- R11: A read of address 3 returns zero. `reg_rdata_o` loads only on a cycle with `reg_rd_i` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_set_i | input | 7 | One-cycle set strobes for raw bits 10..4 |
| ms_lvl_i | input | 4 | Modem-status levels (RI, CTS, DCD, DSR) |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 11 | Write data |
| reg_rdata_o | output | 11 | Registered read data |
| irq_o | output | 1 | Combined interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rt_o | output | 1 | Receive-timeout interrupt |
| irq_ms_o | output | 1 | Modem-status interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Two functions can land in the same cycle: a set strobe from the event logic and a clear write from software aimed at the same bit. The bench drives both on one clock edge, then reads the raw status back and expects the bit to be set. A second pairing puts a pending raw bit against a mask write. Here the line is sampled in the cycle after the write, when it must still be low, and again one cycle later, when it must be high. The same two-sample method is applied to a clear write, to confirm that the line drops exactly one clock late.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned IRQ_W  = 11;
    localparam int unsigned MS_W   = 4;
    localparam int unsigned EV_W   = IRQ_W - MS_W;
    localparam int unsigned EV_LSB = MS_W;
    localparam int unsigned N_GRP  = 5;

    localparam int unsigned BIT_RI  = 0;
    localparam int unsigned BIT_CTS = 1;
    localparam int unsigned BIT_DCD = 2;
    localparam int unsigned BIT_DSR = 3;
    localparam int unsigned BIT_RX  = 4;
    localparam int unsigned BIT_TX  = 5;
    localparam int unsigned BIT_RT  = 6;
    localparam int unsigned BIT_FE  = 7;
    localparam int unsigned BIT_PE  = 8;
    localparam int unsigned BIT_BE  = 9;
    localparam int unsigned BIT_OE  = 10;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    // group indices of the separate interrupt lines
    localparam int unsigned GRP_RX  = 0;
    localparam int unsigned GRP_TX  = 1;
    localparam int unsigned GRP_RT  = 2;
    localparam int unsigned GRP_MS  = 3;
    localparam int unsigned GRP_ERR = 4;

    typedef enum logic [1:0] {
        ADR_MASK     = 2'd0,
        ADR_RAW      = 2'd1,
        ADR_MSK_STAT = 2'd2,
        ADR_CLEAR    = 2'd3
    } reg_addr_e;

    function automatic irq_vec_t grp_mask(int unsigned g);
        irq_vec_t m;
        m = '0;
        case (g)
            GRP_RX:  m[BIT_RX] = 1'b1;
            GRP_TX:  m[BIT_TX] = 1'b1;
            GRP_RT:  m[BIT_RT] = 1'b1;
            GRP_MS: begin
                m[BIT_RI]  = 1'b1;
                m[BIT_CTS] = 1'b1;
                m[BIT_DCD] = 1'b1;
                m[BIT_DSR] = 1'b1;
            end
            GRP_ERR: begin
                m[BIT_FE] = 1'b1;
                m[BIT_PE] = 1'b1;
                m[BIT_BE] = 1'b1;
                m[BIT_OE] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic irq_vec_t all_mask();
        irq_vec_t m;
        m = '0;
        for (int unsigned g = 0; g < N_GRP; g++) begin
            m = m | grp_mask(g);
        end
        return m;
    endfunction

endpackage

// File: rtl/uirq_raw_status.sv
module uirq_raw_status
    import uart_irq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [EV_W-1:0]     ev_set_i,
    input  logic [MS_W-1:0]     ms_lvl_i,
    input  logic                clr_en_i,
    input  irq_vec_t            clr_bits_i,
    output irq_vec_t            raw_o
);

    logic [MS_W-1:0] ms_prev_q;
    logic [MS_W-1:0] ms_chg;
    irq_vec_t        set_vec;
    irq_vec_t        clr_vec;
    irq_vec_t        raw_d;
    irq_vec_t        raw_q;

    always_comb ms_chg  = ms_lvl_i ^ ms_prev_q;
    always_comb set_vec = {ev_set_i, ms_chg};
    always_comb clr_vec = clr_en_i ? clr_bits_i : '0;
    // set is ORed in after the clear, so a collision leaves the bit set
    always_comb raw_d   = (raw_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            raw_q     <= '0;
            ms_prev_q <= '0;
        end else begin
            raw_q     <= raw_d;
            ms_prev_q <= ms_lvl_i;
        end
    end

    assign raw_o = raw_q;

    for (genvar k = 0; k < EV_W; k++) begin : g_ev_chk
        localparam int unsigned B = EV_LSB + k;
        AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ev_set_i[k] |=> raw_q[B]); // R1
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ev_set_i[k] && clr_en_i && clr_bits_i[B]) |=> raw_q[B]); // R5
        AST_EVENT_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_en_i && clr_bits_i[B] && !ev_set_i[k]) |=> !raw_q[B]); // R4
    end

    for (genvar m = 0; m < MS_W; m++) begin : g_ms_chk
        AST_MODEM_CHANGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ms_lvl_i[m] != ms_prev_q[m]) |=> raw_q[m]); // R2
    end

    AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_en_i && (ev_set_i == '0) && (ms_lvl_i == ms_prev_q)) |=> $stable(raw_q)); // R3

endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
    import uart_irq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_i,
    input  irq_vec_t wdata_i,
    output irq_vec_t mask_o
);

    irq_vec_t mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (mask_o == $past(wdata_i))); // R6
    AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(mask_o)); // R6

endmodule

// File: rtl/uirq_line_drive.sv
module uirq_line_drive
    import uart_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  irq_vec_t         raw_i,
    input  irq_vec_t         mask_i,
    output logic             irq_all_o,
    output logic [N_GRP-1:0] irq_grp_o
);

    localparam irq_vec_t ALL_M = all_mask();

    irq_vec_t         active;
    logic [N_GRP-1:0] grp_d;
    logic             all_d;
    logic [N_GRP-1:0] grp_q;
    logic             all_q;

    assign active = raw_i & mask_i;
    assign all_d  = |(active & ALL_M);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam irq_vec_t GM = grp_mask(g);
        assign grp_d[g] = |(active & GM);

        AST_GROUP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_grp_o[g] == |($past(raw_i & mask_i) & GM)); // R8
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            grp_q <= '0;
            all_q <= 1'b0;
        end else begin
            grp_q <= grp_d;
            all_q <= all_d;
        end
    end

    assign irq_grp_o = grp_q;
    assign irq_all_o = all_q;

    AST_COMBINED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_all_o == |$past(raw_i & mask_i)); // R7

endmodule

// File: rtl/uirq_read_port.sv
module uirq_read_port
    import uart_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rd_i,
    input  logic [1:0] addr_i,
    input  irq_vec_t   raw_i,
    input  irq_vec_t   mask_i,
    output irq_vec_t   rdata_o
);

    reg_addr_e sel;
    irq_vec_t  rd_d;
    irq_vec_t  rdata_q;

    assign sel = reg_addr_e'(addr_i);

    always_comb begin
        unique case (sel)
            ADR_MASK:     rd_d = mask_i;
            ADR_RAW:      rd_d = raw_i;
            ADR_MSK_STAT: rd_d = raw_i & mask_i;
            ADR_CLEAR:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_d;
        end
    end

    assign rdata_o = rdata_q;

    AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o)); // R11

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EV_W-1:0]  ev_set_i,
    input  logic [MS_W-1:0]  ms_lvl_i,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [IRQ_W-1:0] reg_wdata_i,
    output logic [IRQ_W-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             irq_rx_o,
    output logic             irq_tx_o,
    output logic             irq_rt_o,
    output logic             irq_ms_o,
    output logic             irq_err_o
);

    reg_addr_e        wsel;
    logic             wr_mask;
    logic             wr_clear;
    irq_vec_t         raw;
    irq_vec_t         mask;
    logic [N_GRP-1:0] grp;

    assign wsel     = reg_addr_e'(reg_addr_i);
    assign wr_mask  = reg_wr_i && (wsel == ADR_MASK);
    assign wr_clear = reg_wr_i && (wsel == ADR_CLEAR);

    uirq_raw_status u_raw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_set_i   (ev_set_i),
        .ms_lvl_i   (ms_lvl_i),
        .clr_en_i   (wr_clear),
        .clr_bits_i (reg_wdata_i),
        .raw_o      (raw)
    );

    uirq_mask_reg u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask)
    );

    uirq_line_drive u_lines (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raw_i     (raw),
        .mask_i    (mask),
        .irq_all_o (irq_o),
        .irq_grp_o (grp)
    );

    uirq_read_port u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .raw_i   (raw),
        .mask_i  (mask),
        .rdata_o (reg_rdata_o)
    );

    assign irq_rx_o  = grp[GRP_RX];
    assign irq_tx_o  = grp[GRP_TX];
    assign irq_rt_o  = grp[GRP_RT];
    assign irq_ms_o  = grp[GRP_MS];
    assign irq_err_o = grp[GRP_ERR];

    // the combined line is never low while a grouped line is high
    AST_COMBINED_COVERS_GROUPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|grp) |-> irq_o); // R7

endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev_set = '0;
    logic [3:0]  ms_lvl = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [10:0] wdata = '0;
    logic [10:0] rdata;
    logic        irq, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ev_set_i    (ev_set),
        .ms_lvl_i    (ms_lvl),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_rx_o    (irq_rx),
        .irq_tx_o    (irq_tx),
        .irq_rt_o    (irq_rt),
        .irq_ms_o    (irq_ms),
        .irq_err_o   (irq_err)
    );

    typedef struct packed {
        logic [10:0] set;
        logic [10:0] mask;
        logic [10:0] clr;
        logic [10:0] exp_raw;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{set: 11'h010, mask: 11'h010, clr: 11'h000, exp_raw: 11'h010},
        '{set: 11'h020, mask: 11'h000, clr: 11'h000, exp_raw: 11'h020},
        '{set: 11'h040, mask: 11'h7FF, clr: 11'h000, exp_raw: 11'h040},
        '{set: 11'h780, mask: 11'h780, clr: 11'h100, exp_raw: 11'h680},
        '{set: 11'h400, mask: 11'h400, clr: 11'h400, exp_raw: 11'h000},
        '{set: 11'h0F0, mask: 11'h0C0, clr: 11'h030, exp_raw: 11'h0C0},
        '{set: 11'h7F0, mask: 11'h020, clr: 11'h000, exp_raw: 11'h7F0}
    };

    // {all, err, ms, rt, tx, rx} from a masked status word
    function automatic logic [5:0] exp_lines(logic [10:0] m);
        return {|m, |m[10:7], |m[3:0], m[6], m[5], m[4]};
    endfunction

    function automatic logic [5:0] act_lines();
        return {irq, irq_err, irq_ms, irq_rt, irq_tx, irq_rx};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [10:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [10:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_set(logic [6:0] e);
        ev_set = e;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [10:0] r;

        // R10: reset state
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 lines after reset", {26'd0, act_lines()}, 32'd0);
        check("R10 rdata after reset", {21'd0, rdata}, 32'd0);
        reg_read(2'd1, r);
        check("R10 raw after reset", {21'd0, r}, 32'd0);
        reg_read(2'd0, r);
        check("R10 mask after reset", {21'd0, r}, 32'd0);

        // table of vectors: R1 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd3, 11'h7FF);
            reg_write(2'd0, VECS[i].mask);
            pulse_set(VECS[i].set[10:4]);
            reg_write(2'd3, VECS[i].clr);
            idle(1);
            reg_read(2'd1, r);
            check("R1/R4 raw status", {21'd0, r}, {21'd0, VECS[i].exp_raw});
            reg_read(2'd2, r);
            check("R6 masked status", {21'd0, r}, {21'd0, VECS[i].exp_raw & VECS[i].mask});
            check("R7/R8 lines", {26'd0, act_lines()},
                  {26'd0, exp_lines(VECS[i].exp_raw & VECS[i].mask)});
        end

        // R9: line one clock after raw update
        reg_write(2'd3, 11'h7FF);
        reg_write(2'd0, 11'h7FF);
        pulse_set(7'b0000010);
        check("R9 tx line not yet high", {31'd0, irq_tx}, 32'd0);
        @(negedge clk);
        check("R9 tx line high", {31'd0, irq_tx}, 32'd1);
        check("R7 combined with tx", {31'd0, irq}, 32'd1);

        // R6 and R9: mask gating and mask write timing
        reg_write(2'd3, 11'h7FF);
        reg_write(2'd0, 11'h000);
        pulse_set(7'b0000001);
        idle(2);
        check("R6 masked rx drives nothing", {31'd0, irq_rx}, 32'd0);
        reg_write(2'd0, 11'h010);
        check("R9 rx line one clock after mask", {31'd0, irq_rx}, 32'd0);
        @(negedge clk);
        check("R9 rx line after mask write", {31'd0, irq_rx}, 32'd1);
        reg_write(2'd3, 11'h010);
        check("R9 rx line lags clear", {31'd0, irq_rx}, 32'd1);
        @(negedge clk);
        check("R4 rx line dropped after clear", {31'd0, irq_rx}, 32'd0);

        // R5: set and clear in the same cycle
        reg_write(2'd3, 11'h7FF);
        ev_set = 7'b0000001;
        addr = 2'd3; wdata = 11'h7FF; wr = 1'b1;
        @(negedge clk);
        ev_set = '0; wr = 1'b0; wdata = '0;
        reg_read(2'd1, r);
        check("R5 set beats clear", {21'd0, r}, 32'h010);

        // R3: sticky bits; R4: zero clear no effect
        pulse_set(7'b1000000);
        idle(20);
        reg_read(2'd1, r);
        check("R3 bits stay set", {21'd0, r}, 32'h410);
        reg_write(2'd3, 11'h000);
        reg_read(2'd1, r);
        check("R4 zero clear no effect", {21'd0, r}, 32'h410);

        // R2: modem level changes
        reg_write(2'd3, 11'h7FF);
        reg_write(2'd0, 11'h00F);
        ms_lvl = 4'b0010;
        @(negedge clk);
        reg_read(2'd1, r);
        check("R2 CTS rise sets bit 1", {21'd0, r}, 32'h002);
        check("R8 modem line", {31'd0, irq_ms}, 32'd1);
        check("R7 combined with modem", {31'd0, irq}, 32'd1);
        reg_write(2'd3, 11'h002);
        idle(3);
        reg_read(2'd1, r);
        check("R2 steady level no set", {21'd0, r}, 32'h000);
        ms_lvl = 4'b0000;
        @(negedge clk);
        reg_read(2'd1, r);
        check("R2 CTS fall sets bit 1", {21'd0, r}, 32'h002);

        // R11: clear address reads zero, rdata holds
        reg_read(2'd3, r);
        check("R11 clear address reads zero", {21'd0, r}, 32'd0);
        pulse_set(7'b0000100);
        idle(2);
        check("R11 rdata holds without read", {21'd0, rdata}, 32'd0);

        // R8: parity event drives only combined and error lines
        reg_write(2'd3, 11'h7FF);
        reg_write(2'd0, 11'h7FF);
        pulse_set(7'b0010000);
        idle(2);
        check("R8 parity group isolation", {26'd0, act_lines()}, {26'd0, 6'b110000});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule